// File: doc/BRIEF.md
# Expansion-Bus I/O Port Slave

This block is the peripheral side of a legacy PC expansion bus. It samples the address lines and the two active-low I/O command strobes on the bus clock. It compares the upper address bits with a base value that can be changed at run time, so several identical cards can share one bus, each at its own base. A matching command opens a window onto sixteen byte-wide internal registers. A read drives the selected data, and a write stores the bus data when the strobe is released.

The bus master decides whether an access is 8 or 16 bits wide and signals this on `wide_i`. The block advertises its own 16-bit capability on `is16_o` whenever the address decodes. A 16-bit access covers an aligned pair of registers across both byte lanes. An 8-bit access uses the low lane only. Typical 8-bit commands last six bus clocks and 16-bit commands three. A configurable wait count holds the channel-ready line low to stretch either kind.

Any cycle with the DMA address-enable high is ignored entirely.

Top module: `io_slave_decoder`

## Requirements
- R1: After reset, `chan_rdy_o` is 1, `data_oe_o` is 0, `data_o` is 0 and all sixteen registers read as 0.
- R2: A command is accepted only when `addr_i[9:4]` equals `base_i` and `aen_i` is 0 on the clock edge where the strobe is first sampled low. Changing `base_i` moves the decoded window. Register index is `addr_i[3:0]`.
- R3: A command with `aen_i` high at its start produces no read drive, no register write and no ready stretch.
- R4: With `wide_i` = 1, index bit 0 is forced to 0. The even register maps to data bits [7:0] and the next register to bits [15:8], for both read and write.
- R5: With `wide_i` = 0, one register is accessed on data bits [7:0]. `data_i[15:8]` is ignored and `data_o[15:8]` reads 0.
- R6: A write takes effect on the clock edge where `iow_ni` is first sampled high again. It stores the `data_i` value sampled on the last edge that the strobe was still low.
- R7: `data_oe_o` rises on the edge after `ior_ni` is first sampled low for a decoded read. It falls on the edge where `ior_ni` is sampled high. `data_o` is 0 whenever `data_oe_o` is 0.
- R8: After a decoded command is accepted, `chan_rdy_o` is low for exactly `wait_cfg_i` clocks (0 to 7). It is never low otherwise.
- R9: `is16_o` is 1 exactly when the current address decodes (base match with `aen_i` low), regardless of the strobes.
- R10: A new command starts only after both strobes were sampled high. A cycle with both strobes low at once is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | 6 | Base compared with address bits [9:4] |
| wait_cfg_i | input | 3 | Wait clocks inserted per command |
| addr_i | input | 10 | I/O address |
| aen_i | input | 1 | DMA address enable, high blocks decoding |
| ior_ni | input | 1 | I/O read strobe, active low |
| iow_ni | input | 1 | I/O write strobe, active low |
| wide_i | input | 1 | Master requests a 16-bit access |
| data_i | input | 16 | Write data from the bus |
| data_o | output | 16 | Read data to the bus |
| data_oe_o | output | 1 | Read data drive enable |
| chan_rdy_o | output | 1 | Channel ready, low inserts wait clocks |
| is16_o | output | 1 | Slave is 16-bit capable at this address |

## Verification
The bench changes the write data on the last low clock of a write strobe. A slave that captures data at the start of the strobe stores the stale value. It issues 16-bit accesses at odd addresses and 8-bit accesses with junk in the upper byte. Broken lane steering or missing alignment then corrupts a neighbouring register or leaks the high byte. Cycles with address-enable high, with both strobes low, and outside a moved base must leave the registers and the drive enable untouched. Wait counts of 0, 3 and 7 expose off-by-one errors in the ready stretch.

// File: rtl/io_slv_pkg.sv
package io_slv_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic {XFER_WRITE = 1'b0, XFER_READ = 1'b1} xfer_dir_e;
endpackage

// File: rtl/io_addr_match.sv
module io_addr_match #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned BASE_W = ADDR_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              aen_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  assign hit_o = !aen_i && (addr_i[ADDR_W-1:IDX_W] == base_i);
  assign idx_o = addr_i[IDX_W-1:0];
endmodule

// File: rtl/io_cmd_ctrl.sv
module io_cmd_ctrl
  import io_slv_pkg::*;
#(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned WAIT_W  = 3,
  parameter bit          WIDE_EN = 1'b1,
  localparam int unsigned LANES  = DATA_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              ior_ni,
  input  logic              iow_ni,
  input  logic              wide_i,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              active_o,
  output xfer_dir_e         dir_o,
  output logic              wide_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              commit_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              ready_o
);
  localparam logic [IDX_W-1:0] ALIGN_MASK = ~IDX_W'(LANES - 1);

  logic              active_q, wide_q, strb_idle_q;
  xfer_dir_e         dir_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WAIT_W-1:0] wcnt_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wide_sel, start, release_cmd;

  assign wide_sel    = wide_i & WIDE_EN;
  // exactly one strobe newly low, after an idle sample
  assign start       = !active_q && strb_idle_q && (ior_ni ^ iow_ni) && hit_i;
  assign release_cmd = active_q && ((dir_q == XFER_READ) ? ior_ni : iow_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      wide_q      <= 1'b0;
      strb_idle_q <= 1'b0;
      dir_q       <= XFER_WRITE;
      idx_q       <= '0;
      wcnt_q      <= '0;
      wdata_q     <= '0;
    end else begin
      strb_idle_q <= ior_ni & iow_ni;
      if (start) begin
        active_q <= 1'b1;
        dir_q    <= ior_ni ? XFER_WRITE : XFER_READ;
        wide_q   <= wide_sel;
        idx_q    <= wide_sel ? (idx_i & ALIGN_MASK) : idx_i;
        wcnt_q   <= wait_cfg_i;
        wdata_q  <= data_i;
      end else if (active_q) begin
        if (release_cmd) begin
          active_q <= 1'b0;
        end else begin
          if (wcnt_q != '0) wcnt_q <= wcnt_q - WAIT_W'(1);
          if (dir_q == XFER_WRITE) wdata_q <= data_i;
        end
      end
    end
  end

  assign active_o = active_q;
  assign dir_o    = dir_q;
  assign wide_o   = wide_q;
  assign idx_o    = idx_q;
  assign commit_o = release_cmd && (dir_q == XFER_WRITE);
  assign wdata_o  = wdata_q;
  assign ready_o  = !(active_q && (wcnt_q != '0));
endmodule

// File: rtl/io_reg_bank.sv
module io_reg_bank
  import io_slv_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned LANES    = DATA_W / BYTE_W,
  localparam int unsigned NUM_REGS = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              wide_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_REGS; r++) regs_q[r] <= '0;
    end else if (commit_i) begin
      if (wide_i) begin
        for (int l = 0; l < LANES; l++)
          regs_q[idx_i | IDX_W'(l)] <= wdata_i[l*BYTE_W +: BYTE_W];
      end else begin
        regs_q[idx_i] <= wdata_i[BYTE_W-1:0];
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_low
      assign rdata_o[BYTE_W-1:0] = regs_q[idx_i];
    end else begin : g_high
      assign rdata_o[l*BYTE_W +: BYTE_W] = wide_i ? regs_q[idx_i | IDX_W'(l)] : '0;
    end
  end
endmodule

// File: rtl/io_slave_decoder.sv
module io_slave_decoder
  import io_slv_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned WAIT_W  = 3,
  parameter bit          WIDE_EN = 1'b1,
  localparam int unsigned BASE_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BASE_W-1:0] base_i,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_i,
  input  logic              ior_ni,
  input  logic              iow_ni,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              chan_rdy_o,
  output logic              is16_o
);
  logic              hit;
  logic [IDX_W-1:0]  idx_dec, idx_cmd;
  logic              active, wide_cmd, commit;
  xfer_dir_e         dir;
  logic [DATA_W-1:0] wdata, rdata;

  io_addr_match #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_match (
    .addr_i (addr_i),
    .base_i (base_i),
    .aen_i  (aen_i),
    .hit_o  (hit),
    .idx_o  (idx_dec)
  );

  io_cmd_ctrl #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W), .WIDE_EN(WIDE_EN)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .idx_i      (idx_dec),
    .ior_ni     (ior_ni),
    .iow_ni     (iow_ni),
    .wide_i     (wide_i),
    .wait_cfg_i (wait_cfg_i),
    .data_i     (data_i),
    .active_o   (active),
    .dir_o      (dir),
    .wide_o     (wide_cmd),
    .idx_o      (idx_cmd),
    .commit_o   (commit),
    .wdata_o    (wdata),
    .ready_o    (chan_rdy_o)
  );

  io_reg_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .wide_i   (wide_cmd),
    .idx_i    (idx_cmd),
    .wdata_i  (wdata),
    .rdata_o  (rdata)
  );

  assign data_oe_o = active && (dir == XFER_READ);
  assign data_o    = data_oe_o ? rdata : '0;
  assign is16_o    = hit && WIDE_EN;
endmodule

// File: rtl/io_slave_decoder_chk.sv
module io_slave_decoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic aen_i,
  input logic ior_ni,
  input logic iow_ni,
  input logic chan_rdy_o,
  input logic data_oe_o,
  input logic is16_o
);
  AST_OE_NOT_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> $past(!aen_i)); // R3
  AST_OE_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> $past(!ior_ni && iow_ni)); // R10
  AST_OE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && ior_ni) |=> !data_oe_o); // R7
  AST_RDY_IN_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_rdy_o |-> $past(!ior_ni || !iow_ni)); // R8
  AST_IS16_NO_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is16_o |-> !aen_i); // R9
endmodule

bind io_slave_decoder io_slave_decoder_chk i_chk (.*);

// File: tb/test_io_slave_decoder.sv
`timescale 1ns/1ps
module test_io_slave_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  base;
  logic [2:0]  wait_cfg;
  logic [9:0]  addr;
  logic        aen, ior_n, iow_n, wide;
  logic [15:0] din, dout;
  logic        oe, rdy, is16;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit mon_req = 1'b0;
  logic [7:0] mdl [16];

  typedef struct { string req; bit oe; logic [15:0] val; } exp_t;
  exp_t exp_q [$];

  always #10 clk = ~clk;

  io_slave_decoder i_io_slave_decoder (
    .clk_i(clk), .rst_ni(rst_n), .base_i(base), .wait_cfg_i(wait_cfg),
    .addr_i(addr), .aen_i(aen), .ior_ni(ior_n), .iow_ni(iow_n), .wide_i(wide),
    .data_i(din), .data_o(dout), .data_oe_o(oe), .chan_rdy_o(rdy), .is16_o(is16)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares read data against scoreboard entries
  initial begin
    forever begin
      @(posedge clk); #5;
      if (mon_req && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, {31'b0, oe}, {31'b0, e.oe});
        chk(e.req, {16'b0, dout}, e.oe ? {16'b0, e.val} : 32'h0);
      end
    end
  end

  task automatic bus_cycle(input bit rd, input bit w, input logic [9:0] a,
                           input logic [15:0] wd, input logic [15:0] wd_late,
                           input int len, input bit dma, input string req);
    int n, lowcnt;
    bit hit;
    logic [3:0] idx;
    exp_t e;
    n = 0; lowcnt = 0;
    hit = !dma && (a[9:4] == base);
    idx = w ? (a[3:0] & 4'hE) : a[3:0];
    @(negedge clk);
    addr = a; wide = w; aen = dma; din = wd;
    if (rd) ior_n = 1'b0; else iow_n = 1'b0;
    do begin
      @(negedge clk); n++;
      if (!rdy) lowcnt++;
    end while ((n < len - 1 || !rdy) && n < 60);
    din = wd_late;
    if (rd) begin
      e.req = req; e.oe = hit;
      e.val = w ? {mdl[idx | 4'h1], mdl[idx]} : {8'h00, mdl[idx]};
      exp_q.push_back(e);
      mon_req = 1'b1;
    end
    @(negedge clk);
    mon_req = 1'b0;
    chk("R8 wait clocks", lowcnt, hit ? 32'(wait_cfg) : 32'd0);
    ior_n = 1'b1; iow_n = 1'b1; aen = 1'b0;
    if (!rd && hit) begin
      mdl[idx] = wd_late[7:0];
      if (w) mdl[idx | 4'h1] = wd_late[15:8];
    end
    @(negedge clk);
    chk("R7 oe after release", {31'b0, oe}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) mdl[r] = 8'h00;
    rst_n = 1'b0; base = 6'h2A; wait_cfg = 3'd0; addr = '0;
    aen = 1'b0; ior_n = 1'b1; iow_n = 1'b1; wide = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready", {31'b0, rdy}, 32'd1);
    chk("R1 oe", {31'b0, oe}, 32'd0);
    chk("R1 data", {16'b0, dout}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 width indicator from decode alone
    addr = 10'h2A5; #1 chk("R9 hit", {31'b0, is16}, 32'd1);
    aen = 1'b1;     #1 chk("R9 dma", {31'b0, is16}, 32'd0);
    aen = 1'b0; addr = 10'h300; #1 chk("R9 miss", {31'b0, is16}, 32'd0);

    bus_cycle(1, 0, 10'h2A3, 0, 0, 6, 0, "R1 reset reg");
    // R4 wide write/read, odd address aligned
    bus_cycle(0, 1, 10'h2A2, 16'hA55A, 16'hA55A, 3, 0, "R4 wide wr");
    bus_cycle(1, 1, 10'h2A2, 0, 0, 3, 0, "R4 wide rd");
    bus_cycle(1, 1, 10'h2A3, 0, 0, 3, 0, "R4 odd aligned rd");
    bus_cycle(1, 0, 10'h2A3, 0, 0, 6, 0, "R5 byte rd high reg");
    bus_cycle(0, 1, 10'h2A5, 16'h6655, 16'h6655, 3, 0, "R4 odd wide wr");
    bus_cycle(1, 0, 10'h2A4, 0, 0, 6, 0, "R4 odd wide wr lane0");
    // R5 byte write ignores upper data
    bus_cycle(0, 0, 10'h2A7, 16'hFF3C, 16'hFF3C, 6, 0, "R5 byte wr");
    bus_cycle(1, 0, 10'h2A7, 0, 0, 6, 0, "R5 byte rd");
    bus_cycle(1, 1, 10'h2A6, 0, 0, 3, 0, "R5 neighbour untouched");
    // R6 late data wins
    bus_cycle(0, 0, 10'h2A9, 16'h0011, 16'h0077, 6, 0, "R6 wr");
    bus_cycle(1, 0, 10'h2A9, 0, 0, 6, 0, "R6 late data");
    // R3 DMA cycles ignored
    bus_cycle(0, 1, 10'h2A2, 16'hFFFF, 16'hFFFF, 3, 1, "R3 dma wr");
    bus_cycle(1, 1, 10'h2A2, 0, 0, 3, 1, "R3 dma rd");
    bus_cycle(1, 1, 10'h2A2, 0, 0, 3, 0, "R3 regs unchanged");
    // R2 base decoding and relocation
    bus_cycle(0, 0, 10'h2B2, 16'h0012, 16'h0012, 6, 0, "R2 miss wr");
    bus_cycle(1, 0, 10'h2A2, 0, 0, 6, 0, "R2 miss no effect");
    base = 6'h2B;
    bus_cycle(1, 1, 10'h2B2, 0, 0, 3, 0, "R2 new base rd");
    bus_cycle(1, 1, 10'h2A2, 0, 0, 3, 0, "R2 old base ignored");
    bus_cycle(0, 1, 10'h2BE, 16'hBEEF, 16'hBEEF, 3, 0, "R2 new base wr");
    bus_cycle(1, 1, 10'h2BE, 0, 0, 3, 0, "R2 new base rdback");
    // R8 wait states
    wait_cfg = 3'd3;
    bus_cycle(1, 1, 10'h2BE, 0, 0, 3, 0, "R8 wait3 rd");
    wait_cfg = 3'd7;
    bus_cycle(0, 0, 10'h2B1, 16'h0042, 16'h0042, 6, 0, "R8 wait7 wr");
    bus_cycle(1, 0, 10'h2B1, 0, 0, 6, 0, "R8 wait7 rd");
    bus_cycle(1, 0, 10'h2A1, 0, 0, 6, 0, "R8 miss no wait");
    wait_cfg = 3'd0;
    // R10 both strobes low ignored
    @(negedge clk);
    addr = 10'h2B1; din = 16'h00EE; ior_n = 1'b0; iow_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 both low oe", {31'b0, oe}, 32'd0);
      chk("R10 both low rdy", {31'b0, rdy}, 32'd1);
    end
    ior_n = 1'b1; iow_n = 1'b1;
    @(negedge clk);
    bus_cycle(1, 0, 10'h2B1, 0, 0, 6, 0, "R10 reg unchanged");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule